// File: doc/BRIEF.md
# Slot Transmit Request Controller

This block is the transmit control and status word for a frame buffer of eight fixed slots. The buffer is 2 KB, and each 256-byte slot holds one complete frame. Software queues a frame by writing a 1 to that slot's send bit. The block keeps one waiting flag per slot. It offers the waiting slots to a downstream transmit arbiter one at a time, always the lowest-numbered slot first. When the arbiter reports that the frame has been sent, the block clears that slot's flag, records the slot number as the last one sent, and raises an interrupt.

Software has two ways to learn of completions. It can poll the waiting flags, or it can take the interrupt. Any access to the control word, read or write, acknowledges the interrupt. The control word sits at one word offset of a 32-bit word-addressed register space. The block ignores accesses at every other offset.

The arbiter side is a valid/ready pair: `arb_req` acts as valid and `arb_grant` acts as ready. Once `arb_req` is raised, it stays high with `arb_slot` unchanged until the cycle in which `arb_grant` is sampled high. After that, no new offer is made until a one-cycle `arb_done` pulse marks the end of the transmission. The register port and `irq` are plain control pins. Read data is combinational in the cycle of the read strobe.

Top module: `slot_txreq_ctrl`

## Requirements
- R1: After reset, the waiting flags, the last-sent field, `arb_req` and `irq` are all 0.
- R2: A write at the control offset with data bit i (0..7) set raises the waiting flag of slot i. That flag reads back at bit 8+i from the cycle after the write. A data bit of 0 leaves its slot's flag as it was.
- R3: A read at the control offset returns 0 in bits 7:0 and in bits 31:19, whatever was written to them.
- R4: Writing 1 for a slot whose flag is already set is ignored. That slot gets exactly one offer and one completion.
- R5: When the block is idle and some flags are set, `arb_req` rises one cycle later. `arb_slot` then carries the lowest-numbered waiting slot. Both stay unchanged until a grant is sampled.
- R6: After the cycle in which `arb_req` and `arb_grant` are both high, `arb_req` stays low until an `arb_done` pulse has been received.
- R7: An `arb_done` pulse after a grant clears the waiting flag of the granted slot and loads its number into bits 18:16, which hold the last slot sent.
- R8: `irq` rises in the cycle after a completion. It stays high until a read or write at the control offset, and it is low from the cycle after that access.
- R9: If a completion and an access at the control offset fall in the same cycle, the completion wins and `irq` is high afterwards.
- R10: Reads and writes at other offsets return 0. They neither set flags nor clear `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| arb_req | output | 1 | Offer to the arbiter (valid) |
| arb_slot | output | 3 | Slot number of the current offer |
| arb_grant | input | 1 | Arbiter accepts the offer (ready) |
| arb_done | input | 1 | One-cycle pulse: granted frame has been sent |
| irq | output | 1 | Completion interrupt |

## Verification
Directed steps first queue two sparse slots, 2 and 5. The bench then holds the grant off and writes again to a slot that is already waiting. This separates "hold the offer" from "re-offer", and "ignore" from "queue twice". Separate steps place a completion in the same cycle as an acknowledging read, and make accesses at a neighbouring offset. These show whether `irq` priority and address decode are right. A scoreboard phase then drives a responding arbiter with a full mask, a mask with only the end slots, an alternating mask and a single slot. Each mask is written twice. Every grant is compared with a queue of the expected ascending slot order, so a wrong order, a lost slot or a duplicated slot is each caught.

// File: rtl/slot_txreq_pkg.sv
package slot_txreq_pkg;
  // Handshake state toward the transmit arbiter
  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_OFFER  = 2'd1,
    HS_FLIGHT = 2'd2
  } hs_state_e;
endpackage

// File: rtl/slot_pending.sv
module slot_pending #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set_mask,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_SLOTS-1:0] pend
);
  // One flag per slot. A completion clear wins over a set in the same
  // cycle. A set on a flag that is already high changes nothing.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         flag_q <= 1'b0;
      else if (clr_en && (clr_idx == IDX_W'(g)))          flag_q <= 1'b0;
      else if (set_mask[g])                               flag_q <= 1'b1;
    end
    assign pend[g] = flag_q;
  end
endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] pend,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  // Fixed priority: the lowest-numbered waiting slot goes first
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tx_handshake_fsm.sv
module tx_handshake_fsm
  import slot_txreq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_pend,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             grant,
  input  logic             done,
  input  logic             ack_access,
  output logic             req,
  output logic [IDX_W-1:0] slot,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic [IDX_W-1:0] last_idx,
  output logic             irq
);
  hs_state_e        state_q;
  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] last_q;
  logic             irq_q;
  logic             finish;

  assign finish = (state_q == HS_FLIGHT) && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      slot_q  <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        HS_IDLE: if (any_pend) begin
          slot_q  <= pick_idx;
          state_q <= HS_OFFER;
        end
        HS_OFFER:  if (grant) state_q <= HS_FLIGHT;
        HS_FLIGHT: if (done) begin
          last_q  <= slot_q;
          state_q <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  // A new completion outranks an acknowledging access in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (finish)     irq_q <= 1'b1;
    else if (ack_access) irq_q <= 1'b0;
  end

  assign req      = (state_q == HS_OFFER);
  assign slot     = slot_q;
  assign clr_en   = finish;
  assign clr_idx  = slot_q;
  assign last_idx = last_q;
  assign irq      = irq_q;
endmodule

// File: rtl/slot_txreq_ctrl.sv
module slot_txreq_ctrl #(
  parameter int          NUM_SLOTS = 8,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [7:0]  REG_WORD  = 8'h20,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int WAIT_LSB = NUM_SLOTS,
  localparam int LAST_LSB = 2 * NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              arb_req,
  output logic [IDX_W-1:0]  arb_slot,
  input  logic              arb_grant,
  input  logic              arb_done,
  output logic              irq
);
  logic                 hit;
  logic                 ack_access;
  logic [NUM_SLOTS-1:0] set_mask;
  logic [NUM_SLOTS-1:0] pend_q;
  logic                 any_pend;
  logic [IDX_W-1:0]     pick_idx;
  logic                 clr_en;
  logic [IDX_W-1:0]     clr_idx;
  logic [IDX_W-1:0]     last_idx;
  logic                 unused_wdata;

  assign hit          = (reg_addr == REG_WORD[ADDR_W-1:0]);
  assign ack_access   = hit && (reg_wr || reg_rd);
  assign set_mask     = (hit && reg_wr) ? reg_wdata[NUM_SLOTS-1:0] : '0;
  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_SLOTS];

  slot_pending #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .pend     (pend_q)
  );

  slot_picker #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .pend (pend_q),
    .any  (any_pend),
    .idx  (pick_idx)
  );

  tx_handshake_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_pend   (any_pend),
    .pick_idx   (pick_idx),
    .grant      (arb_grant),
    .done       (arb_done),
    .ack_access (ack_access),
    .req        (arb_req),
    .slot       (arb_slot),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .last_idx   (last_idx),
    .irq        (irq)
  );

  // Send bits read as zero; waiting flags and last slot are placed above them
  always_comb begin
    reg_rdata = '0;
    if (hit && reg_rd) begin
      reg_rdata[WAIT_LSB +: NUM_SLOTS] = pend_q;
      reg_rdata[LAST_LSB +: IDX_W]     = last_idx;
    end
  end
endmodule

// File: rtl/slot_txreq_ctrl_chk.sv
module slot_txreq_ctrl_chk #(
  parameter int         NUM_SLOTS = 8,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 32,
  parameter logic [7:0] REG_WORD  = 8'h20,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int LAST_LSB = 2 * NUM_SLOTS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic                 arb_req,
  input logic [IDX_W-1:0]     arb_slot,
  input logic                 arb_grant,
  input logic                 arb_done,
  input logic                 irq,
  input logic [NUM_SLOTS-1:0] pend
);
  logic                 granted_q;
  logic                 acc;
  logic [NUM_SLOTS-1:0] below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     granted_q <= 1'b0;
    else if (arb_req && arb_grant)  granted_q <= 1'b1;
    else if (arb_done)              granted_q <= 1'b0;
  end

  assign acc   = (reg_addr == REG_WORD[ADDR_W-1:0]) && (reg_wr || reg_rd);
  assign below = (NUM_SLOTS'(1) << arb_slot) - NUM_SLOTS'(1);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req && !arb_grant |=> arb_req && $stable(arb_slot)); // R5
  AST_REQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_req) |-> pend[arb_slot] && ((pend & below) == '0)); // R5
  AST_QUIET_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    granted_q |-> !arb_req); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    granted_q && arb_done |=> !pend[$past(arb_slot)]); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    granted_q && arb_done |=> irq); // R8
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq && acc && !(granted_q && arb_done) |=> !irq); // R9
  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !acc |=> irq); // R10
  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> reg_rdata[NUM_SLOTS-1:0] == '0
               && reg_rdata[DATA_W-1:LAST_LSB+IDX_W] == '0); // R3
endmodule

bind slot_txreq_ctrl slot_txreq_ctrl_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .REG_WORD  (REG_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .arb_req   (arb_req),
  .arb_slot  (arb_slot),
  .arb_grant (arb_grant),
  .arb_done  (arb_done),
  .irq       (irq),
  .pend      (pend_q)
);

// File: tb/slot_txreq_ctrl_tb.sv
`timescale 1ns/1ps
module slot_txreq_ctrl_tb;
  localparam logic [7:0] CTL   = 8'h20;
  localparam logic [7:0] OTHER = 8'h21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        arb_req;
  logic [2:0]  arb_slot;
  logic        m_grant = 1'b0, m_done = 1'b0;
  logic        a_grant = 1'b0, a_done = 1'b0;
  logic        irq;
  logic        auto_en = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  slot_txreq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .arb_req   (arb_req),
    .arb_slot  (arb_slot),
    .arb_grant (m_grant | a_grant),
    .arb_done  (m_done | a_done),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_grant();
    m_grant = 1'b1; @(negedge clk); m_grant = 1'b0;
  endtask

  task automatic pulse_done();
    m_done = 1'b1; @(negedge clk); m_done = 1'b0;
  endtask

  // Scoreboard driver: queue expected ascending slot order, write mask twice
  task automatic sb_send(input logic [7:0] mask);
    logic [31:0] rd;
    int top = 0;
    for (int i = 0; i < 8; i++) if (mask[i]) begin exp_q.push_back(i); top = i; end
    do_write(CTL, {24'h0, mask});
    do_write(CTL, {24'h0, mask}); // R4 duplicate must be ignored
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    check("R7 irq after burst", {31'h0, irq}, 1);
    do_read(CTL, rd);
    check("R7 flags clear, last slot", rd, {13'h0, 3'(top), 16'h0});
    check("R4 no extra offer", {31'h0, arb_req}, 0);
  endtask

  // Responding arbiter and monitor: compares each granted slot with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (auto_en && arb_req) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4 unexpected offer: actual slot %0d expected none", arb_slot);
        end else begin
          int e;
          e = exp_q.pop_front();
          check("R5 scoreboard order", {29'h0, arb_slot}, e);
        end
        a_grant = 1'b1; @(negedge clk); a_grant = 1'b0;
        repeat (2) @(negedge clk);
        a_done = 1'b1; @(negedge clk); a_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 arb_req", {31'h0, arb_req}, 0);
    check("R1 irq", {31'h0, irq}, 0);
    do_read(CTL, rd);
    check("R1 register", rd, 0);

    // R2 zero data queues nothing
    do_write(CTL, 32'hFFFF_FF00);
    do_read(CTL, rd);
    check("R2 zero send bits", rd, 0);
    check("R2 no offer", {31'h0, arb_req}, 0);

    // R10 other offset
    do_write(OTHER, 32'h0000_00FF);
    do_read(OTHER, rd);
    check("R10 other read", rd, 0);
    do_read(CTL, rd);
    check("R10 other write no flags", rd, 0);

    // R2/R3 queue slots 2 and 5
    do_write(CTL, 32'hFFFF_FF24);
    do_read(CTL, rd);
    check("R2 R3 flags readback", rd, 32'h0000_2400);
    check("R5 offer up", {31'h0, arb_req}, 1);
    check("R5 lowest slot", {29'h0, arb_slot}, 2);
    repeat (3) @(negedge clk);
    check("R5 held without grant", {28'h0, arb_req, arb_slot}, {28'h0, 1'b1, 3'd2});
    do_write(CTL, 32'h0000_0004);
    do_read(CTL, rd);
    check("R4 rewrite ignored", rd, 32'h0000_2400);

    // R6 quiet between grant and done
    pulse_grant();
    check("R6 req drops after grant", {31'h0, arb_req}, 0);
    repeat (3) @(negedge clk);
    check("R6 still quiet", {31'h0, arb_req}, 0);
    pulse_done();
    check("R8 irq rises", {31'h0, irq}, 1);
    @(negedge clk);
    do_read(CTL, rd);
    check("R7 flag cleared, last=2", rd, 32'h0002_2000);
    check("R8 irq cleared by read", {31'h0, irq}, 0);
    check("R5 next slot offered", {28'h0, arb_req, arb_slot}, {28'h0, 1'b1, 3'd5});

    // R9 completion and acknowledging read in the same cycle
    pulse_grant();
    @(negedge clk);
    m_done = 1'b1;
    do_read(CTL, rd);
    m_done = 1'b0;
    check("R9 irq kept", {31'h0, irq}, 1);
    do_read(OTHER, rd);
    do_write(OTHER, 32'h0000_00FF);
    check("R10 irq not cleared by other offset", {31'h0, irq}, 1);
    do_read(CTL, rd);
    check("R7 last=5 no flags", rd, 32'h0005_0000);
    check("R8 irq cleared", {31'h0, irq}, 0);

    // Scoreboard phase
    auto_en = 1'b1;
    sb_send(8'hFF);
    sb_send(8'h81);
    sb_send(8'h5A);
    sb_send(8'h01);
    auto_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule